// File: doc/BRIEF.md
# Pulse-Transformer PWM Encoder

This block turns a peak-current PWM decision into the two drive lines of one isolation pulse transformer. It has its own switching-period counter, clocked by the system clock. Each period starts with the primary switch turned on. The period ends its on-window at a selectable duty limit. A turn-off request from the current comparator ends the on time early.

In encoded mode the two lines are driven in opposite phase. The line `drv_a` is high from the start of the period up to the duty limit, and the line `drv_b` is high from the limit to the end of the period. The moment the on time ends is carried as a short notch, during which both lines are low. The notch lies inside the first part of the period, so the far side can recover both the switching edges and the turn-off instant from one winding. In bypass mode, `drv_a` carries plain PWM and `drv_b` carries a clock that is in phase with it. Configuration inputs are taken in only at a period start.

Top module: `pt_pwm_encoder`

## Requirements
- R1: In encoded mode, for a phase p (0 to PERIOD-1) below the limit L, the outputs are drv_a=1 and drv_b=0. This holds except inside a notch. For p >= L the outputs are drv_a=0 and drv_b=1.
- R2: The limit L is PERIOD/2 when lim_ext=0 and 3*PERIOD/4 when lim_ext=1.
- R3: If off_req is high at the edge that enters phase t, with t < L, the on time ends. Both outputs are then 0 for phases t up to min(t+NOTCH, L)-1. Encoded mode then resumes drv_a=1 until L.
- R4: A request sampled at the edge entering phase 0 gives 0% duty. The notch then starts at phase 0.
- R5: A request at a phase >= L has no effect on the outputs. Only the first request in a period acts, so off_req held high for a whole period acts like a single request at phase 0.
- R6: When enc_bypass=1, drv_a is high from phase 0 until the request phase or L, whichever comes first. drv_b is high for phases below PERIOD/2.
- R7: lim_ext and enc_bypass are sampled only at the edge that enters phase 0. Changes at other times do not affect the current period.
- R8: During rst, and on the cycle after an edge with en=0, both outputs are 0. The first edge with en=1 enters phase 0.
- R9: In encoded mode the two outputs are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low forces idle |
| off_req | input | 1 | Turn-off request from the current comparator |
| lim_ext | input | 1 | Duty limit select: 0 = 50%, 1 = 75% |
| enc_bypass | input | 1 | 1 = plain PWM plus clock, 0 = notch encoding |
| drv_a | output | 1 | Positive transformer drive |
| drv_b | output | 1 | Negative transformer drive |

## Verification
Some properties are checked by assertions on every cycle:
- the two outputs never overlap in encoded mode;
- drv_b rises in encoded mode only at the limit phase;
- drv_a rises in bypass mode only at phase 0;
- a run of both-low cycles never exceeds the notch length;
- the outputs go quiet after enable drops.

Other behaviour can only be shown by the sweeps in the bench:
- the exact phase at which the notch lands, for every request phase;
- that late requests are ignored;
- the 0% case;
- that select changes in mid-period have no effect.

// File: rtl/ptenc_pkg.sv
package ptenc_pkg;

    localparam int unsigned DEF_PERIOD = 64;  // system clocks per switching period
    localparam int unsigned DEF_NOTCH  = 19;  // about 150 ns at 125 MHz

    typedef struct packed {
        logic raw;   // encoding bypassed
        logic ext;   // 75% duty limit
    } ptenc_cfg_t;

    typedef enum logic [1:0] {
        DRV_OFF  = 2'b00,
        DRV_NEG  = 2'b01,
        DRV_POS  = 2'b10
    } ptenc_drv_t;

    function automatic int unsigned limit_phase(int unsigned period, logic ext);
        return ext ? (period * 3) / 4 : period / 2;
    endfunction

endpackage

// File: rtl/ptenc_timer.sv
module ptenc_timer
    import ptenc_pkg::*;
#(
    parameter int unsigned PERIOD = DEF_PERIOD,
    localparam int unsigned PW = $clog2(PERIOD)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  ptenc_cfg_t    cfg_in,
    output logic [PW-1:0] ph_nx,
    output logic          run_nx,
    output logic          start_nx,
    output ptenc_cfg_t    cfg_nx,
    output logic [PW-1:0] ph_q,
    output logic          run_q,
    output ptenc_cfg_t    cfg_q
);
    localparam logic [PW-1:0] LAST = PW'(PERIOD - 1);

    logic wrap;

    always_comb begin
        wrap     = !run_q || (ph_q == LAST);
        run_nx   = en;
        start_nx = en && wrap;
        ph_nx    = (!en || wrap) ? '0 : ph_q + PW'(1);
        cfg_nx   = start_nx ? cfg_in : cfg_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            ph_q  <= '0;
            cfg_q <= '0;
        end else begin
            run_q <= run_nx;
            ph_q  <= ph_nx;
            cfg_q <= cfg_nx;
        end
    end

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (run_q && ph_q == LAST && en) |=> (ph_q == '0)); // R2

endmodule

// File: rtl/ptenc_gate.sv
module ptenc_gate
    import ptenc_pkg::*;
#(
    parameter int unsigned PERIOD = DEF_PERIOD,
    parameter int unsigned NOTCH  = DEF_NOTCH,
    localparam int unsigned PW = $clog2(PERIOD),
    localparam int unsigned NW = $clog2(NOTCH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run_nx,
    input  logic          start_nx,
    input  logic [PW-1:0] ph_nx,
    input  ptenc_cfg_t    cfg_nx,
    input  logic          off_req,
    output logic          in_pos_nx,
    output logic          on_nx,
    output logic          notch_nx
);
    localparam logic [NW-1:0] NL_FULL = NW'(NOTCH);

    logic          on_q;
    logic [NW-1:0] nl_q;
    logic [NW-1:0] nl_nx;
    logic          on_base;
    logic          cut;

    always_comb begin
        in_pos_nx = 32'(ph_nx) < limit_phase(PERIOD, cfg_nx.ext);
        on_base   = start_nx ? 1'b1 : on_q;
        on_nx     = run_nx && in_pos_nx && on_base && !off_req;
        cut       = run_nx && in_pos_nx && on_base && off_req;
        if (!run_nx || !in_pos_nx || start_nx && !cut)
            nl_nx = '0;
        else if (cut)
            nl_nx = NL_FULL;
        else if (nl_q != '0)
            nl_nx = nl_q - NW'(1);
        else
            nl_nx = '0;
        notch_nx = (nl_nx != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            on_q <= 1'b0;
            nl_q <= '0;
        end else begin
            on_q <= on_nx;
            nl_q <= nl_nx;
        end
    end

    AST_NOTCH_FROM_CUT: assert property (@(posedge clk) disable iff (rst)
        (nl_q == NL_FULL) |-> $past(on_q) || ($past(nl_q) == '0)); // R5

endmodule

// File: rtl/ptenc_drive.sv
module ptenc_drive
    import ptenc_pkg::*;
#(
    parameter int unsigned PERIOD = DEF_PERIOD,
    localparam int unsigned PW = $clog2(PERIOD)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run_nx,
    input  logic [PW-1:0] ph_nx,
    input  ptenc_cfg_t    cfg_nx,
    input  logic          in_pos_nx,
    input  logic          on_nx,
    input  logic          notch_nx,
    output logic          drv_a,
    output logic          drv_b
);
    ptenc_drv_t lvl;
    logic       half_nx;

    always_comb begin
        half_nx = 32'(ph_nx) < (PERIOD / 2);
        if (!run_nx)
            lvl = DRV_OFF;
        else if (cfg_nx.raw)
            lvl = ptenc_drv_t'({on_nx, half_nx});
        else if (!in_pos_nx)
            lvl = DRV_NEG;
        else if (notch_nx)
            lvl = DRV_OFF;
        else
            lvl = DRV_POS;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            drv_a <= 1'b0;
            drv_b <= 1'b0;
        end else begin
            drv_a <= lvl[1];
            drv_b <= lvl[0];
        end
    end

endmodule

// File: rtl/pt_pwm_encoder.sv
module pt_pwm_encoder
    import ptenc_pkg::*;
#(
    parameter int unsigned PERIOD = DEF_PERIOD,
    parameter int unsigned NOTCH  = DEF_NOTCH
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic off_req,
    input  logic lim_ext,
    input  logic enc_bypass,
    output logic drv_a,
    output logic drv_b
);
    localparam int unsigned PW = $clog2(PERIOD);
    localparam int unsigned CW = $clog2(PERIOD + 1);

    ptenc_cfg_t    cfg_in, cfg_nx, cfg_q;
    logic [PW-1:0] ph_nx, ph_q;
    logic          run_nx, run_q, start_nx;
    logic          in_pos_nx, on_nx, notch_nx;

    assign cfg_in = '{raw: enc_bypass, ext: lim_ext};

    ptenc_timer #(.PERIOD(PERIOD)) u_timer (
        .clk(clk), .rst(rst), .en(en), .cfg_in(cfg_in),
        .ph_nx(ph_nx), .run_nx(run_nx), .start_nx(start_nx), .cfg_nx(cfg_nx),
        .ph_q(ph_q), .run_q(run_q), .cfg_q(cfg_q)
    );

    ptenc_gate #(.PERIOD(PERIOD), .NOTCH(NOTCH)) u_gate (
        .clk(clk), .rst(rst), .run_nx(run_nx), .start_nx(start_nx),
        .ph_nx(ph_nx), .cfg_nx(cfg_nx), .off_req(off_req),
        .in_pos_nx(in_pos_nx), .on_nx(on_nx), .notch_nx(notch_nx)
    );

    ptenc_drive #(.PERIOD(PERIOD)) u_drive (
        .clk(clk), .rst(rst), .run_nx(run_nx), .ph_nx(ph_nx), .cfg_nx(cfg_nx),
        .in_pos_nx(in_pos_nx), .on_nx(on_nx), .notch_nx(notch_nx),
        .drv_a(drv_a), .drv_b(drv_b)
    );

    // Length of the current run of both-low cycles in encoded mode
    logic [CW-1:0] low_run;
    always_ff @(posedge clk) begin
        if (rst || !(run_q && !cfg_q.raw && !drv_a && !drv_b))
            low_run <= '0;
        else if (low_run != CW'(PERIOD))
            low_run <= low_run + CW'(1);
    end

    AST_ENC_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        (run_q && !cfg_q.raw) |-> !(drv_a && drv_b)); // R9

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!drv_a && !drv_b)); // R8

    AST_NOTCH_BOUND: assert property (@(posedge clk) disable iff (rst)
        32'(low_run) <= NOTCH); // R3

    AST_NEG_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (run_q && !cfg_q.raw && $rose(drv_b)) |-> (32'(ph_q) == limit_phase(PERIOD, cfg_q.ext))); // R2

    AST_PWM_RISE_AT_START: assert property (@(posedge clk) disable iff (rst)
        (run_q && cfg_q.raw && $rose(drv_a)) |-> (ph_q == '0)); // R6

endmodule

// File: tb/pt_pwm_encoder_bench.sv
module pt_pwm_encoder_bench;
    localparam int P = 64;
    localparam int N = 19;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0;
    logic off_req = 1'b0;
    logic lim_ext = 1'b0;
    logic enc_bypass = 1'b0;
    logic drv_a, drv_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pt_pwm_encoder #(.PERIOD(P), .NOTCH(N)) u_pt_pwm_encoder (
        .clk(clk), .rst(rst), .en(en), .off_req(off_req),
        .lim_ext(lim_ext), .enc_bypass(enc_bypass),
        .drv_a(drv_a), .drv_b(drv_b)
    );

    function automatic logic [1:0] model(int p, int t, bit raw, bit ext);
        int lim = ext ? (P * 3) / 4 : P / 2;
        if (raw)
            return {p < ((t < lim) ? t : lim), p < P / 2};
        if (p >= lim)
            return 2'b01;
        if (t < lim && p >= t && p < t + N)
            return 2'b00;
        return 2'b10;
    endfunction

    task automatic check(string req, logic [1:0] got, logic [1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got a,b=%b expected %b", req, got, exp);
        end
    endtask

    // One sweep: every request phase, then a request held high all period
    task automatic run_cfg(bit raw, bit ext);
        int lim = ext ? (P * 3) / 4 : P / 2;
        @(negedge clk);
        en = 1'b0; off_req = 1'b0; enc_bypass = raw; lim_ext = ext;
        @(negedge clk);
        check("R8 idle", {drv_a, drv_b}, 2'b00);
        en = 1'b1;
        for (int per = 0; per <= P + 1; per++) begin
            bit hold = (per == P + 1);
            int t = hold ? 0 : per;
            for (int p = 0; p < P; p++) begin
                off_req = hold ? 1'b1 : (p == per);
                // selects inverted except at the edge entering phase 0 (R7)
                enc_bypass = (p == 0) ? raw : !raw;
                lim_ext    = (p == 0) ? ext : !ext;
                @(negedge clk);
                begin
                    string tag;
                    logic [1:0] e = model(p, t, raw, ext);
                    if (raw) tag = "R6";
                    else if (hold) tag = "R5 held";
                    else if (t < lim && p >= t && p < t + N) tag = (t == 0) ? "R4" : "R3";
                    else if (t >= lim && t < P) tag = "R5 late";
                    else if (ext && p >= P / 2 && p < lim) tag = "R2";
                    else tag = "R1";
                    check($sformatf("%s R7 raw=%0d ext=%0d t=%0d p=%0d", tag, raw, ext, t, p),
                          {drv_a, drv_b}, e);
                    if (!raw)
                        check("R9", {1'b0, drv_a && drv_b}, 2'b00);
                end
            end
        end
        en = 1'b0; off_req = 1'b0;
        @(negedge clk);
        check("R8 disable", {drv_a, drv_b}, 2'b00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R8 reset", {drv_a, drv_b}, 2'b00);
        rst = 1'b0;
        run_cfg(1'b0, 1'b0);
        run_cfg(1'b0, 1'b1);
        run_cfg(1'b1, 1'b0);
        run_cfg(1'b1, 1'b1);
        // reset in mid-run, then restart at phase 0
        @(negedge clk);
        enc_bypass = 1'b0; lim_ext = 1'b0; off_req = 1'b0; en = 1'b1;
        repeat (10) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R8 mid reset", {drv_a, drv_b}, 2'b00);
        rst = 1'b0;
        @(negedge clk);
        check("R8 restart phase 0", {drv_a, drv_b}, 2'b10);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hang expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule